// File: doc/BRIEF.md
# Two-Stage Dual-Clock Sample Queue with Source Pacing

This block sits between a bursty producer of audio sample words and a consumer that runs on a clean, low-jitter crystal clock. Words enter on the producer's clock and leave on the consumer's clock. The two clocks are fully independent. Averaged over time, the two sides must move words at the same rate. Short-term differences and clock jitter are absorbed by the storage in between.

The storage is two dual-clock FIFO stages in series, and together they act as one deeper queue. Words move from the upstream stage to the downstream stage on their own, whenever the upstream stage holds data and the downstream stage has room. A registered output slot presents the head word to the consumer.

Each stage reports whether it is at least half full. A small controller in the producer's clock domain turns the two flags into pacing outputs for the source. The pacing law is picked at build time: either faster/slower requests or a run/stop level. Sticky error bits record a write into a full queue and a read from an empty one.

Top module: `chained_async_queue`

## Requirements
- R1: Every accepted word reaches the read port exactly once and in write order, under bursty writes, spaced writes and a consumer that stalls at intervals, with the write and read clocks unrelated.
- R2: With the consumer stalled, the queue holds 2*DEPTH+1 words (33 by default: one stage of DEPTH, the other stage of DEPTH, plus the output slot). A write offered while the upstream stage is full is dropped.
- R3: `ovf_err` goes high the cycle after `wr_valid` is seen while the upstream stage is full. It stays high until an `ovf_clr` cycle with no new overflow. It never rises when no write was dropped.
- R4: `udf_err` goes high the cycle after `rd_ready` is high while `rd_valid` is low. It stays high until a `udf_clr` cycle with no new underflow.
- R5: While `rd_valid` is high and `rd_ready` is low, `rd_valid` and `rd_data` hold. When the queue has run dry, `rd_valid` is low and `rd_data` keeps the last word delivered.
- R6: In faster/slower mode (`CTRL_MODE` = CTRL_SPEED), `src_fast` is high while the upstream stage holds at least DEPTH/2 words. `src_slow` is high while the downstream stage holds at least DEPTH/2 words and the upstream stage holds fewer. The two are never high together, and `src_run` is tied high.
- R7: In run/stop mode (`CTRL_MODE` = CTRL_STARTSTOP), `src_run` rises when the upstream half flag is set. It falls when the downstream half flag is set while the upstream one is clear. Otherwise it holds its value. `src_fast` and `src_slow` stay low.
- R8: After reset, `rd_valid`=0, `rd_data`=0, both error bits are 0, `src_fast`=0, `src_slow`=0 and `src_run`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Producer-side clock |
| wr_rst_n | input | 1 | Synchronous active-low reset, write domain |
| wr_valid | input | 1 | Offer of a word this cycle |
| wr_data | input | DW | Word offered |
| ovf_clr | input | 1 | Clears the overflow bit (write domain) |
| ovf_err | output | 1 | Sticky overflow indication |
| src_fast | output | 1 | Request for a faster source (faster/slower mode) |
| src_slow | output | 1 | Request for a slower source (faster/slower mode) |
| src_run | output | 1 | Source run level (run/stop mode) |
| rd_clk | input | 1 | Consumer-side crystal clock |
| rd_rst_n | input | 1 | Synchronous active-low reset, read domain |
| rd_ready | input | 1 | Consumer takes the presented word |
| rd_valid | output | 1 | A word is presented |
| rd_data | output | DW | Presented word |
| udf_clr | input | 1 | Clears the underflow bit (read domain) |
| udf_err | output | 1 | Sticky underflow indication |

## Verification
The bench drives a write clock and a read clock with unrelated periods. It then goes after the points where crossing logic usually breaks. It fills the queue one word at a time with the consumer stalled, and reads the pacing outputs at the exact word counts on either side of each half threshold. A threshold that is off by one, or stage flags that are swapped, shows up as the wrong pacing level at word 8, 9, 24 or 25. It overfills past 33 words: a full test that is too eager or too late either loses a word inside the queue or delivers words that should have been dropped. The scoreboard shows either one as a data mismatch. Back-to-back bursts and a stuttering consumer check ordering across the stage-to-stage hand-off, where a broken pointer crossing repeats or skips words. The bench also checks that the output holds during a stall and keeps the last word when the queue is dry.

// File: rtl/caq_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the chained dual-clock queue.
package caq_pkg;

    // Pacing law applied to the source
    typedef enum logic {
        CTRL_SPEED     = 1'b0,   // faster/slower requests
        CTRL_STARTSTOP = 1'b1    // run/stop level
    } caq_ctrl_mode_e;

endpackage

// File: rtl/caq_sync2.sv
`timescale 1ns/1ps
// Two-flop synchronizer for a bus.
// Assumes the bus is Gray-coded or a single level, so that at most one
// bit changes per source cycle. Synchronous active-low reset to zero.
module caq_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Capture the foreign value, then settle it one more stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/caq_async_stage.sv
`timescale 1ns/1ps
// One dual-clock FIFO stage with Gray-coded pointers.
// Depth is 2**AW and AW must be at least 2. A word is read at the current
// read address (show-ahead). whalf is a registered flag in the write domain,
// high when the stage holds at least half its depth. The count behind it
// uses the synchronized read pointer, so it can run a little high.
// Each side has its own synchronous active-low reset. Both resets are
// expected to be asserted together.
module caq_async_stage #(
    parameter int DW = 32,
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          wrst_n,
    input  logic          push,
    input  logic [DW-1:0] din,
    output logic          full,
    output logic          whalf,
    input  logic          rclk,
    input  logic          rrst_n,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic          empty
);
    localparam int DEPTH = 1 << AW;
    localparam int PW    = AW + 1;
    localparam int HALF  = DEPTH / 2;

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wbin, wbin_nxt, wgray, rq_w, rbin_w;
    logic [PW-1:0] rbin, rbin_nxt, rgray, wq_r;

    // ---------------- write domain ----------------
    assign full     = (wgray == (rq_w ^ {2'b11, {(PW-2){1'b0}}}));
    assign wbin_nxt = wbin + PW'(push && !full);

    // Advance the write pointer in binary and Gray form
    always_ff @(posedge wclk) begin
        if (!wrst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else begin
            wbin  <= wbin_nxt;
            wgray <= wbin_nxt ^ (wbin_nxt >> 1);
        end
    end

    // Store an accepted word
    always_ff @(posedge wclk) begin
        if (push && !full)
            mem[wbin[AW-1:0]] <= din;
    end

    // Bring the read pointer into the write domain
    caq_sync2 #(.W(PW)) u_rsync (.clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rq_w));

    // Decode the synchronized Gray read pointer back to binary
    always_comb begin
        for (int i = 0; i < PW; i++)
            rbin_w[i] = ^(rq_w >> i);
    end

    // Register the half-full level from the write-side occupancy
    always_ff @(posedge wclk) begin
        if (!wrst_n) whalf <= 1'b0;
        else         whalf <= ((wbin_nxt - rbin_w) >= PW'(HALF));
    end

    // ---------------- read domain ----------------
    assign empty    = (rgray == wq_r);
    assign rbin_nxt = rbin + PW'(pop && !empty);
    assign dout     = mem[rbin[AW-1:0]];

    // Advance the read pointer in binary and Gray form
    always_ff @(posedge rclk) begin
        if (!rrst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else begin
            rbin  <= rbin_nxt;
            rgray <= rbin_nxt ^ (rbin_nxt >> 1);
        end
    end

    // Bring the write pointer into the read domain
    caq_sync2 #(.W(PW)) u_wsync (.clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wq_r));

    // R1: a Gray pointer that crosses domains moves by at most one bit per cycle
    p_gray_step_r1: assert property (@(posedge wclk) disable iff (!wrst_n)
        $countones(wgray ^ $past(wgray)) <= 1);

    // R1: the surrounding logic never pops an empty stage
    p_pop_nonempty_r1: assert property (@(posedge rclk) disable iff (!rrst_n)
        pop |-> !empty);
endmodule

// File: rtl/caq_rate_ctrl.sv
`timescale 1ns/1ps
// Pacing controller in the source clock domain.
// Both half flags must already be synchronous to clk. The outputs are
// registered levels. The unused outputs of a mode are tied to constants.
module caq_rate_ctrl #(
    parameter caq_pkg::caq_ctrl_mode_e MODE = caq_pkg::CTRL_SPEED
) (
    input  logic clk,
    input  logic rst_n,
    input  logic up_half,
    input  logic dn_half,
    output logic fast,
    output logic slow,
    output logic run
);
    generate
        if (MODE == caq_pkg::CTRL_SPEED) begin : g_speed
            assign run = 1'b1;

            // Upstream filling asks for speed; downstream alone asks to slow
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    fast <= 1'b0;
                    slow <= 1'b0;
                end else begin
                    fast <= up_half;
                    slow <= dn_half && !up_half;
                end
            end

            // R6: never both requests at once
            p_speed_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0({fast, slow}));
        end else begin : g_startstop
            assign fast = 1'b0;
            assign slow = 1'b0;

            // Upstream flag starts the flow, downstream flag alone stops it
            always_ff @(posedge clk) begin
                if (!rst_n)       run <= 1'b1;
                else if (up_half) run <= 1'b1;
                else if (dn_half) run <= 1'b0;
            end

            // R7: the start condition wins
            p_run_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
                up_half |=> run);
            // R7: the stop condition
            p_run_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (dn_half && !up_half) |=> !run);
        end
    endgenerate
endmodule

// File: rtl/chained_async_queue.sv
`timescale 1ns/1ps
// Two dual-clock FIFO stages in series, with an output slot and source pacing.
// Stage one crosses from wr_clk to rd_clk. Stage two and the output slot run
// on rd_clk. Words move between the stages whenever they can. The downstream
// half flag is synchronized into wr_clk; the upstream flag is already there.
// Assumes both resets are asserted together, each held for several cycles of
// its own clock.
module chained_async_queue #(
    parameter int DW = 32,
    parameter int AW = 4,
    parameter caq_pkg::caq_ctrl_mode_e CTRL_MODE = caq_pkg::CTRL_SPEED
) (
    input  logic          wr_clk,
    input  logic          wr_rst_n,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    input  logic          ovf_clr,
    output logic          ovf_err,
    output logic          src_fast,
    output logic          src_slow,
    output logic          src_run,
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic          rd_ready,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    input  logic          udf_clr,
    output logic          udf_err
);
    logic          s1_full, s1_half, s1_empty;
    logic [DW-1:0] s1_dout;
    logic          s2_full, s2_half, s2_empty;
    logic [DW-1:0] s2_dout;
    logic          xfer, load, dn_half_w;

    assign xfer = !s1_empty && !s2_full;
    assign load = !s2_empty && (!rd_valid || rd_ready);

    caq_async_stage #(.DW(DW), .AW(AW)) u_up (
        .wclk(wr_clk), .wrst_n(wr_rst_n), .push(wr_valid), .din(wr_data),
        .full(s1_full), .whalf(s1_half),
        .rclk(rd_clk), .rrst_n(rd_rst_n), .pop(xfer), .dout(s1_dout),
        .empty(s1_empty)
    );

    caq_async_stage #(.DW(DW), .AW(AW)) u_dn (
        .wclk(rd_clk), .wrst_n(rd_rst_n), .push(xfer), .din(s1_dout),
        .full(s2_full), .whalf(s2_half),
        .rclk(rd_clk), .rrst_n(rd_rst_n), .pop(load), .dout(s2_dout),
        .empty(s2_empty)
    );

    caq_sync2 #(.W(1)) u_half_sync (
        .clk(wr_clk), .rst_n(wr_rst_n), .d(s2_half), .q(dn_half_w)
    );

    caq_rate_ctrl #(.MODE(CTRL_MODE)) u_ctrl (
        .clk(wr_clk), .rst_n(wr_rst_n), .up_half(s1_half), .dn_half(dn_half_w),
        .fast(src_fast), .slow(src_slow), .run(src_run)
    );

    // Output slot: load the head word when it is empty or being taken
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else if (load) begin
            rd_valid <= 1'b1;
            rd_data  <= s2_dout;
        end else if (rd_ready) begin
            rd_valid <= 1'b0;
        end
    end

    // Record a dropped write
    always_ff @(posedge wr_clk) begin
        if (!wr_rst_n) ovf_err <= 1'b0;
        else           ovf_err <= (ovf_err && !ovf_clr) || (wr_valid && s1_full);
    end

    // Record a read attempted on an empty port
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) udf_err <= 1'b0;
        else           udf_err <= (udf_err && !udf_clr) || (rd_ready && !rd_valid);
    end

    // R3: a write into a full queue is flagged
    p_ovf_sticky_r3: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_valid && s1_full) |=> ovf_err);
    // R3: a clear with no new overflow removes the flag
    p_ovf_clear_r3: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (ovf_clr && !(wr_valid && s1_full)) |=> !ovf_err);
    // R4: a read on an empty port is flagged
    p_udf_sticky_r4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_ready && !rd_valid) |=> udf_err);
    // R5: a presented word holds until taken
    p_hold_r5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
    // R5: with nothing to load, the data output does not move
    p_dry_hold_r5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (!rd_valid && s2_empty) |=> $stable(rd_data));
endmodule

// File: tb/test_chained_async_queue.sv
`timescale 1ns/1ps
module test_chained_async_queue;
    logic        wr_clk = 1'b0;
    logic        rd_clk = 1'b0;
    logic        wr_rst_n = 1'b0, rd_rst_n = 1'b0;
    logic        wr_valid = 1'b0, ovf_clr = 1'b0, udf_clr = 1'b0, rd_ready = 1'b0;
    logic [31:0] wr_data = '0;
    logic        a_ovf, a_fast, a_slow, a_run, a_valid, a_udf;
    logic        b_ovf, b_fast, b_slow, b_run, b_valid, b_udf;
    logic [31:0] a_data, b_data;

    int          n_checks = 0;
    int          n_fail   = 0;
    logic [31:0] exp_q[$];
    bit          done  = 1'b0;
    bit          wdone = 1'b0;

    always #5   wr_clk = ~wr_clk;   // 100 MHz
    always #6.5 rd_clk = ~rd_clk;   // unrelated read clock

    chained_async_queue #(.CTRL_MODE(caq_pkg::CTRL_SPEED)) i_chained_async_queue (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .ovf_clr(ovf_clr), .ovf_err(a_ovf), .src_fast(a_fast), .src_slow(a_slow),
        .src_run(a_run), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_ready(rd_ready),
        .rd_valid(a_valid), .rd_data(a_data), .udf_clr(udf_clr), .udf_err(a_udf)
    );

    chained_async_queue #(.CTRL_MODE(caq_pkg::CTRL_STARTSTOP)) i_chained_async_queue_ss (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .ovf_clr(ovf_clr), .ovf_err(b_ovf), .src_fast(b_fast), .src_slow(b_slow),
        .src_run(b_run), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_ready(rd_ready),
        .rd_valid(b_valid), .rd_data(b_data), .udf_clr(udf_clr), .udf_err(b_udf)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write_word(input logic [31:0] d, input int gap, input bit keep);
        @(posedge wr_clk); #1;
        wr_valid = 1'b1;
        wr_data  = d;
        if (keep) exp_q.push_back(d);
        @(posedge wr_clk); #1;
        wr_valid = 1'b0;
        repeat (gap) @(posedge wr_clk);
    endtask

    task automatic set_ready(input logic v);
        @(posedge rd_clk); #1;
        rd_ready = v;
    endtask

    task automatic settle();
        repeat (30) @(posedge wr_clk);
        #1;
    endtask

    task automatic drain_wait();
        int t = 0;
        while (exp_q.size() != 0 && t < 5000) begin
            @(posedge rd_clk);
            t++;
        end
        repeat (10) @(posedge rd_clk);
        #1;
    endtask

    // Scoreboard monitor: a word taken at the next edge is compared here
    always @(negedge rd_clk) begin
        if (rd_rst_n && a_valid && rd_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R1 unexpected word", a_data, 32'h0);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                chk(a_data == e, "R1 order speed-mode copy", a_data, e);
                chk(b_data == e && b_valid, "R1 order run/stop copy", b_data, e);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge wr_clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (6) @(posedge rd_clk);
        @(posedge wr_clk); #1;
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;
        settle();

        // R8 reset state
        chk(a_valid == 1'b0, "R8 rd_valid", a_valid, 0);
        chk(a_data == 32'h0, "R8 rd_data", a_data, 0);
        chk(a_ovf == 0 && a_udf == 0, "R8 error bits", {a_ovf, a_udf}, 0);
        chk(a_fast == 0 && a_slow == 0 && a_run == 1, "R8 speed pacing", {a_fast, a_slow, a_run}, 3'b001);
        chk(b_run == 1 && b_fast == 0 && b_slow == 0, "R8 run/stop pacing", {b_fast, b_slow, b_run}, 3'b001);

        // Fill with consumer stalled: R2, R5, R6, R7, R3
        for (int i = 1; i <= 40; i++) begin
            write_word(i, 10, i <= 33);
            if (i == 8 || i == 9 || i == 24 || i == 25 || i == 33) settle();
            if (i == 8) begin
                chk(a_slow == 0 && a_fast == 0, "R6 below downstream half", {a_fast, a_slow}, 0);
                chk(b_run == 1, "R7 still running at 8", b_run, 1);
            end
            if (i == 9) begin
                chk(a_slow == 1 && a_fast == 0, "R6 slow at downstream half", {a_fast, a_slow}, 2'b01);
                chk(b_run == 0, "R7 stop at downstream half", b_run, 0);
                chk(b_fast == 0 && b_slow == 0, "R7 speed outputs idle", {b_fast, b_slow}, 0);
                chk(a_valid == 1 && a_data == 32'd1, "R5 head held during stall", a_data, 1);
            end
            if (i == 24) begin
                chk(a_fast == 0 && a_slow == 1, "R6 below upstream half", {a_fast, a_slow}, 2'b01);
                chk(b_run == 0, "R7 stays stopped at 24", b_run, 0);
            end
            if (i == 25) begin
                chk(a_fast == 1 && a_slow == 0, "R6 fast at upstream half", {a_fast, a_slow}, 2'b10);
                chk(b_run == 1, "R7 restart at upstream half", b_run, 1);
                chk(a_run == 1, "R6 run tied high", a_run, 1);
            end
            if (i == 33) chk(a_ovf == 0, "R3 no overflow at capacity", a_ovf, 0);
        end
        settle();
        chk(a_ovf == 1 && b_ovf == 1, "R3 overflow flagged", {a_ovf, b_ovf}, 2'b11);
        chk(a_valid == 1 && a_data == 32'd1, "R5 head still held", a_data, 1);

        @(posedge wr_clk); #1 ovf_clr = 1'b1;
        @(posedge wr_clk); #1 ovf_clr = 1'b0;
        settle();
        chk(a_ovf == 0, "R3 overflow cleared", a_ovf, 0);

        // Drain: exactly 33 words come out (R2) in order (R1)
        set_ready(1'b1);
        drain_wait();
        chk(exp_q.size() == 0, "R2 all stored words delivered", exp_q.size(), 0);
        chk(a_valid == 0, "R5 valid low when dry", a_valid, 0);
        chk(a_data == 32'd33, "R2 last word is 33, R5 held when dry", a_data, 33);
        chk(a_udf == 1, "R4 underflow flagged", a_udf, 1);
        settle();
        chk(a_fast == 0 && a_slow == 0, "R6 idle when empty", {a_fast, a_slow}, 0);
        chk(b_run == 0, "R7 holds stop after drain", b_run, 0);

        set_ready(1'b0);
        @(posedge rd_clk); #1 udf_clr = 1'b1;
        @(posedge rd_clk); #1 udf_clr = 1'b0;
        repeat (3) @(posedge rd_clk); #1;
        chk(a_udf == 0 && b_udf == 0, "R4 underflow cleared", {a_udf, b_udf}, 0);

        // Back-to-back burst with an always-ready consumer (R1)
        set_ready(1'b1);
        for (int i = 0; i < 20; i++) begin
            @(posedge wr_clk); #1;
            wr_valid = 1'b1;
            wr_data  = 32'hB000_0000 + i;
            exp_q.push_back(32'hB000_0000 + i);
        end
        @(posedge wr_clk); #1 wr_valid = 1'b0;
        drain_wait();
        chk(exp_q.size() == 0, "R1 burst fully delivered", exp_q.size(), 0);

        // Spaced writes with a stuttering consumer (R1, R3)
        fork
            begin
                for (int i = 0; i < 300; i++) write_word(32'hA500_0000 + i, 2, 1'b1);
                wdone = 1'b1;
            end
            begin
                int k = 0;
                while (!wdone) begin
                    set_ready(k % 3 != 0);
                    k++;
                end
            end
        join
        set_ready(1'b1);
        drain_wait();
        chk(exp_q.size() == 0, "R1 stream fully delivered", exp_q.size(), 0);
        chk(a_ovf == 0, "R3 no spurious overflow", a_ovf, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule